// File: doc/BRIEF.md
# Pulse-Density Modulated Output Generator

This block turns a 16-bit level into a single-bit stream whose proportion of ones equals the level divided by 2^16. Software, or any bus master, programs it through a write-only parallel port that has a strobe, an address and data. One address holds the level. A second address holds a run flag in its least significant data bit.

While the block runs, a first-order accumulator adds the level on every clock. The carry out of that addition is captured in a flip-flop that drives the output pin. When the run flag is clear, the accumulator is held at zero and the pin stays low. An external low-pass filter, which is not part of this block, recovers an analog value from the stream.

The write port is a plain control port. It has no back-pressure: a write is accepted on every rising clock edge where the strobe is high. There is no read path.

Top module: `pdm_tx`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it falls, `pdm_o` is 0. Reset clears the stored level to 0 and the run flag to off.
- R2: A write with `wr_addr` = 0x0000 stores `wr_data` as the level on the rising edge where `wr_en` is high.
- R3: A write with `wr_addr` = 0x0002 copies `wr_data` bit 0 into the run flag: 1 means run, 0 means stop.
- R4: While the run flag is off, the accumulator is held at zero. `pdm_o` is 0 from the second edge after the flag goes off, whatever level is stored.
- R5: With level 0x8000 and the accumulator starting from zero, `pdm_o` is 0 after the first running edge. After that it alternates 1, 0, 1, 0 on every clock.
- R6: With level 0x0000, `pdm_o` stays 0 on every clock while running.
- R7: With level 0x4000 and the accumulator starting from zero, `pdm_o` is high exactly on the 4th, 8th, 12th and later multiples of four running edges.
- R8: A level written while running is used from the next edge onward, without a new write to the run flag.
- R9: A write to any address other than 0x0000 and 0x0002 changes neither the level nor the run flag.
- R10: Starting from zero, the number of ones on `pdm_o` over 2^16 consecutive running clocks equals the level exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address (0x0000 level, 0x0002 run flag) |
| wr_data | input | 16 | Write data |
| pdm_o | output | 1 | Registered pulse-density output |

## Verification
A corrupted accumulator shows up at the pin within one clock. It does so as a broken pattern at the exact levels 0x8000 and 0x4000, and as a wrong ones count over a full 2^16-cycle window. A corrupted level register or a wrong address decode shows up as a missing, early or late edge in the pattern during the first few cycles after the write. Because the pin is a single register behind the sum, every fault appears at `pdm_o` one edge after the state that caused it.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int unsigned PDM_DATA_W = 16;
  localparam int unsigned PDM_ADDR_W = 16;
  localparam logic [PDM_ADDR_W-1:0] PDM_LEVEL_ADDR = 16'h0000;
  localparam logic [PDM_ADDR_W-1:0] PDM_CTRL_ADDR  = 16'h0002;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_CTRL  = 2'd2
  } pdm_sel_e;
endpackage

// File: rtl/pdm_regfile.sv
module pdm_regfile
  import pdm_pkg::*;
#(
  parameter int unsigned DATA_W = PDM_DATA_W,
  parameter int unsigned ADDR_W = PDM_ADDR_W,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = PDM_LEVEL_ADDR,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = PDM_CTRL_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] level_o,
  output logic              run_o
);
  pdm_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == LEVEL_ADDR)     sel = SEL_LEVEL;
      else if (wr_addr == CTRL_ADDR) sel = SEL_CTRL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= '0;
      run_o   <= 1'b0;
    end else begin
      if (sel == SEL_LEVEL) level_o <= wr_data;
      if (sel == SEL_CTRL)  run_o   <= wr_data[0];
    end
  end

  // R2: a level write lands on the strobe edge
  p_level_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LEVEL_ADDR) |=> (level_o == $past(wr_data)));

  // R3: a control write copies bit 0
  p_run_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_ADDR) |=> (run_o == $past(wr_data[0])));

  // R9: stray addresses leave both registers alone
  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != LEVEL_ADDR && wr_addr != CTRL_ADDR)
      |=> ($stable(level_o) && $stable(run_o)));
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [DATA_W-1:0] level_i,
  output logic              pdm_o
);
  localparam int unsigned SUM_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] HALF = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, acc_q} + {1'b0, level_i};

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      acc_q <= '0;
      pdm_o <= 1'b0;
    end else begin
      acc_q <= sum[DATA_W-1:0];
      pdm_o <= sum[SUM_W-1];
    end
  end

  // R4: a high output needs the run flag on the edge before
  p_off_low_r4: assert property (@(posedge clk) disable iff (rst)
    pdm_o |-> $past(run_i));

  // R4: a stopped block holds the accumulator at zero
  p_acc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (acc_q == '0));

  // R6: a zero level never carries
  p_zero_level_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && level_i == '0) |=> !pdm_o);

  // R5: a half-scale level toggles the output every clock
  p_half_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(run_i && level_i == HALF) && $past(run_i && level_i == HALF, 2))
      |-> (pdm_o != $past(pdm_o)));
endmodule

// File: rtl/pdm_tx.sv
module pdm_tx
  import pdm_pkg::*;
#(
  parameter int unsigned DATA_W = PDM_DATA_W,
  parameter int unsigned ADDR_W = PDM_ADDR_W,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = PDM_LEVEL_ADDR,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = PDM_CTRL_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pdm_o
);
  logic [DATA_W-1:0] level;
  logic              run;

  pdm_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .LEVEL_ADDR(LEVEL_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .level_o(level), .run_o(run)
  );

  pdm_accum #(.DATA_W(DATA_W)) u_accum (
    .clk(clk), .rst(rst), .run_i(run), .level_i(level), .pdm_o(pdm_o)
  );

  // R1: output low through reset and the edge that follows it
  p_reset_low_r1: assert property (@(posedge clk)
    $past(rst) |-> !pdm_o);
endmodule

// File: tb/pdm_tx_test.sv
module pdm_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pdm_o;

  int errors = 0;
  int checks = 0;

  pdm_tx uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pdm_o(pdm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic stop_and_settle();
    bus_write(16'h0002, 16'h0000);
    @(negedge clk);
  endtask

  task automatic expect_pattern(input string req, input int n, input int period, input int phase);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(pdm_o == ((k % period) == phase), req, pdm_o, int'((k % period) == phase));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(pdm_o == 1'b0, "R1 during reset", pdm_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pdm_o == 1'b0, "R1 after reset", pdm_o, 0);
  endtask

  task automatic t_disabled();
    bus_write(16'h0000, 16'h8000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pdm_o == 1'b0, "R4 level while stopped", pdm_o, 0);
    end
  endtask

  task automatic t_half();
    bus_write(16'h0002, 16'h0001);
    check(pdm_o == 1'b0, "R3 enable edge", pdm_o, 0);
    expect_pattern("R5 half alternates", 8, 2, 0);
    stop_and_settle();
    check(pdm_o == 1'b0, "R4 stop forces low", pdm_o, 0);
  endtask

  task automatic t_zero();
    bus_write(16'h0000, 16'h0000);
    bus_write(16'h0002, 16'h0001);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(pdm_o == 1'b0, "R6 zero level", pdm_o, 0);
    end
    stop_and_settle();
  endtask

  task automatic t_quarter();
    bus_write(16'h0000, 16'h4000);
    bus_write(16'h0002, 16'h0001);
    expect_pattern("R7 quarter level", 12, 4, 0);
    stop_and_settle();
  endtask

  task automatic t_live_change();
    bus_write(16'h0000, 16'h0000);
    bus_write(16'h0002, 16'h0001);
    @(negedge clk);
    bus_write(16'h0000, 16'h8000);
    check(pdm_o == 1'b0, "R8 write edge", pdm_o, 0);
    @(negedge clk);
    check(pdm_o == 1'b0, "R8 first new edge", pdm_o, 0);
    @(negedge clk);
    check(pdm_o == 1'b1, "R8 new level active", pdm_o, 1);
    stop_and_settle();
  endtask

  task automatic t_stray();
    bus_write(16'h0000, 16'h0000);
    bus_write(16'h0002, 16'h0001);
    bus_write(16'h0004, 16'h8000);
    bus_write(16'h0001, 16'hFFFF);
    bus_write(16'h8000, 16'h8000);
    bus_write(16'h0006, 16'h0000);
    bus_write(16'h0003, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pdm_o == 1'b0, "R9 level unchanged by stray writes", pdm_o, 0);
    end
    bus_write(16'h0000, 16'h8000);
    @(negedge clk);
    @(negedge clk);
    check(pdm_o == 1'b1, "R9 run flag unchanged by stray writes", pdm_o, 1);
    stop_and_settle();
  endtask

  task automatic t_window(input logic [15:0] lvl);
    int ones;
    ones = 0;
    bus_write(16'h0000, lvl);
    bus_write(16'h0002, 16'h0001);
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      if (pdm_o) ones++;
    end
    check(ones == int'(lvl), "R10 ones per window", ones, int'(lvl));
    stop_and_settle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_disabled();
        t_half();
        t_zero();
        t_quarter();
        t_live_change();
        t_stray();
        t_window(16'hA5C3);
      end
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule